// File: doc/BRIEF.md
# APB Wait-State Contract Monitor

This block sits beside an APB subordinate and watches the bus without driving it. Whenever the subordinate stretches an access by holding PREADY low, the monitor checks that the manager keeps the bus frozen. It also checks that the access phase is not dropped early, that read data does not move across the wait, and that every access finishes within a programmable number of cycles. Every rule is built from registered snapshots and comparators, so it runs in silicon or emulation as well as in simulation.

A broken rule sets its own sticky flag, and a combined error output follows the OR of all flags. The first break after a clear is recorded as a rule code plus the address on the bus in that cycle. Software or a test harness pulses a synchronous clear to re-arm the flags and the record.

Top module: `apb_wait_checker`

## Requirements
- R1: After a wait cycle (psel && penable && !pready), a change of paddr, pwrite, pprot or pstrb in the next cycle sets err_hold (flag bit 0). A change of pwdata sets it only when the waiting access is a write; on a read, pwdata changes are ignored.
- R2: After a wait cycle, penable low in the next cycle sets err_enable (flag bit 1).
- R3: After a wait cycle of a read access, a change of prdata in the next cycle sets err_rdata (flag bit 2). This applies to the completing cycle too.
- R4: The cycle in which penable rises counts as access cycle 1. If access cycle number max_wait is reached with penable high and no completion (psel && penable && pready), err_timeout (flag bit 3) is set. The count restarts at every rise of penable and stops at completion or when penable falls. max_wait = 0 disables the watchdog.
- R5: Flags are sticky until clr is sampled high. A violation in the same cycle as clr is still recorded after that edge.
- R6: The first violation after reset or clr sets first_valid and latches first_code (0 hold, 1 enable, 2 read data, 3 timeout) and first_addr = paddr of that cycle. Later violations do not overwrite these. When several rules break in the same cycle, the lowest code wins.
- R7: While rst_n is low, all flags, the first-violation record and all tracking state are cleared.
- R8: err_any is high exactly when at least one flag is set.
- R9: A violation in a cycle shows on the outputs right after the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Synchronous clear of flags and record |
| max_wait | input | CNT_W | Completion bound in access cycles, 0 = off |
| psel | input | 1 | Select |
| penable | input | 1 | Access phase enable |
| pwrite | input | 1 | Write when high |
| paddr | input | ADDR_W | Address |
| pprot | input | 3 | Protection attributes |
| pstrb | input | DATA_W/8 | Write byte strobes |
| pwdata | input | DATA_W | Write data |
| pready | input | 1 | Subordinate ready |
| prdata | input | DATA_W | Read data |
| err_hold | output | 1 | Sticky: bus moved during wait |
| err_enable | output | 1 | Sticky: penable fell during wait |
| err_rdata | output | 1 | Sticky: read data moved after wait |
| err_timeout | output | 1 | Sticky: completion bound exceeded |
| err_any | output | 1 | OR of all flags |
| first_valid | output | 1 | A first violation is recorded |
| first_code | output | 2 | Rule code of first violation |
| first_addr | output | ADDR_W | paddr at first violation |

## Verification
Two things can fall in the same cycle here: the clear pulse and a fresh violation. The bench breaks the hold rule in the exact cycle that clr is high, while an older timeout flag is still set. Afterwards it expects only the hold flag, with the record re-latched to code 0 and the new address. It also breaks two rules in one cycle (address move and penable drop) to judge the lowest-code priority of the record.

// File: rtl/apb_wait_checker.sv
module apb_wait_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CNT_W-1:0]  max_wait,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [2:0]        pprot,
  input  logic [STRB_W-1:0] pstrb,
  input  logic [DATA_W-1:0] pwdata,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata,
  output logic              err_hold,
  output logic              err_enable,
  output logic              err_rdata,
  output logic              err_timeout,
  output logic              err_any,
  output logic              first_valid,
  output logic [1:0]        first_code,
  output logic [ADDR_W-1:0] first_addr
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wait_c, done_c, rise_c, pend_c;
  assign wait_c = psel & penable & ~pready;
  assign done_c = psel & penable & pready;

  logic              pen_q, wait_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        prot_q;
  logic [STRB_W-1:0] strb_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pen_q   <= 1'b0;
      wait_q  <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      prot_q  <= '0;
      strb_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      pen_q  <= penable;
      wait_q <= wait_c;
      if (wait_c) begin
        wr_q    <= pwrite;
        addr_q  <= paddr;
        prot_q  <= pprot;
        strb_q  <= pstrb;
        wdata_q <= pwdata;
        rdata_q <= prdata;
      end
    end
  end

  // watchdog: cnt_q holds the number of the previous access cycle
  logic             act_q;
  logic [CNT_W-1:0] cnt_q, idx_c;
  assign rise_c = penable & ~pen_q;
  assign idx_c  = rise_c ? CNT_W'(1) : (cnt_q == CNT_MAX ? cnt_q : cnt_q + 1'b1);
  assign pend_c = (rise_c | act_q) & penable & ~done_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= pend_c;
      cnt_q <= pend_c ? idx_c : '0;
    end
  end

  logic [3:0] viol;
  assign viol[0] = wait_q & ((paddr != addr_q) | (pwrite != wr_q) | (pprot != prot_q) |
                             (pstrb != strb_q) | (wr_q & (pwdata != wdata_q)));
  assign viol[1] = wait_q & ~penable;
  assign viol[2] = wait_q & ~wr_q & (prdata != rdata_q);
  assign viol[3] = pend_c & (max_wait != '0) & (idx_c == max_wait);

  logic [1:0] code_c;
  always_comb begin
    code_c = 2'd3;
    for (int i = 2; i >= 0; i--)
      if (viol[i]) code_c = 2'(i);
  end

  logic [3:0] flags_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q     <= '0;
      first_valid <= 1'b0;
      first_code  <= '0;
      first_addr  <= '0;
    end else begin
      flags_q <= (clr ? 4'b0 : flags_q) | viol;
      if ((~first_valid | clr) & (|viol)) begin
        first_valid <= 1'b1;
        first_code  <= code_c;
        first_addr  <= paddr;
      end else if (clr) begin
        first_valid <= 1'b0;
      end
    end
  end

  assign {err_timeout, err_rdata, err_enable, err_hold} = flags_q;
  assign err_any = |flags_q;

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(psel && penable && !pready) && paddr != $past(paddr)) |=> err_hold); // R1
  AST_ENABLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(psel && penable && !pready) && !penable) |=> err_enable); // R2
  AST_RDATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(psel && penable && !pready && !pwrite) && prdata != $past(prdata)) |=> err_rdata); // R3
  AST_TMO_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> $past(penable)); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_timeout && !clr) |=> err_timeout); // R5
  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (first_valid && !clr) |=> ($stable(first_code) && $stable(first_addr))); // R6
  AST_FIRST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(first_valid) |-> err_any); // R8

endmodule

// File: tb/apb_wait_checker_tb_top.sv
module apb_wait_checker_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, clr, psel, penable, pwrite, pready;
  logic [7:0] max_wait, paddr, pwdata, prdata;
  logic [2:0] pprot;
  logic [0:0] pstrb;
  logic       err_hold, err_enable, err_rdata, err_timeout, err_any, first_valid;
  logic [1:0] first_code;
  logic [7:0] first_addr;

  apb_wait_checker #(.ADDR_W(8), .DATA_W(8), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .max_wait(max_wait),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pprot(pprot), .pstrb(pstrb), .pwdata(pwdata), .pready(pready), .prdata(prdata),
    .err_hold(err_hold), .err_enable(err_enable), .err_rdata(err_rdata),
    .err_timeout(err_timeout), .err_any(err_any), .first_valid(first_valid),
    .first_code(first_code), .first_addr(first_addr));

  int nchk = 0, nfail = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] flags();
    return {err_timeout, err_rdata, err_enable, err_hold};
  endfunction

  task automatic cyc(logic c, logic s, logic e, logic r, logic w,
                     logic [7:0] a, logic [7:0] wd, logic [7:0] rd);
    @(negedge clk);
    clr = c; psel = s; penable = e; pready = r; pwrite = w;
    paddr = a; pwdata = wd; prdata = rd;
    @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic       c, s, e, r, w;
    logic [7:0] a, wd, rd;
    logic [3:0] ef;
    logic [1:0] ec;
  } vec_t;

  localparam int NV = 37;
  // ef bits: {timeout, rdata, enable, hold}; max_wait = 4
  localparam vec_t VEC [NV] = '{
    '{0,0,0,0,0,8'h00,8'h00,8'h00,4'b0000,2'd0},
    '{0,1,0,0,1,8'h10,8'hAA,8'h00,4'b0000,2'd0},
    '{0,1,1,1,1,8'h10,8'hAA,8'h00,4'b0000,2'd0},
    '{0,0,0,0,0,8'h00,8'h00,8'h00,4'b0000,2'd0},
    '{0,1,0,0,0,8'h20,8'h00,8'h00,4'b0000,2'd0},
    '{0,1,1,0,0,8'h20,8'h00,8'h11,4'b0000,2'd0},
    '{0,1,1,0,0,8'h20,8'h00,8'h11,4'b0000,2'd0},
    '{0,1,1,1,0,8'h20,8'h00,8'h11,4'b0000,2'd0},
    '{0,0,0,0,0,8'h00,8'h00,8'h00,4'b0000,2'd0},
    '{0,1,0,0,1,8'h30,8'h77,8'h00,4'b0000,2'd0},
    '{0,1,1,0,1,8'h30,8'h77,8'h00,4'b0000,2'd0},
    '{0,1,1,0,1,8'h31,8'h77,8'h00,4'b0001,2'd0},
    '{0,1,1,1,1,8'h31,8'h77,8'h00,4'b0001,2'd0},
    '{1,0,0,0,0,8'h00,8'h00,8'h00,4'b0000,2'd0},
    '{0,1,0,0,0,8'h40,8'h00,8'h00,4'b0000,2'd0},
    '{0,1,1,0,0,8'h40,8'h00,8'h22,4'b0000,2'd0},
    '{0,1,0,0,0,8'h40,8'h00,8'h22,4'b0010,2'd1},
    '{1,0,0,0,0,8'h00,8'h00,8'h00,4'b0000,2'd0},
    '{0,1,0,0,0,8'h50,8'h00,8'h00,4'b0000,2'd0},
    '{0,1,1,0,0,8'h50,8'h00,8'h33,4'b0000,2'd0},
    '{0,1,1,0,0,8'h50,8'h00,8'h44,4'b0100,2'd2},
    '{0,1,1,0,0,8'h50,8'h00,8'h44,4'b0100,2'd2},
    '{0,1,1,0,0,8'h50,8'h00,8'h44,4'b1100,2'd2},
    '{0,1,1,1,0,8'h50,8'h00,8'h44,4'b1100,2'd2},
    '{1,0,0,0,0,8'h00,8'h00,8'h00,4'b0000,2'd0},
    '{0,1,0,0,1,8'h60,8'h01,8'h00,4'b0000,2'd0},
    '{0,1,1,0,1,8'h60,8'h01,8'h00,4'b0000,2'd0},
    '{0,1,1,0,1,8'h60,8'h01,8'h00,4'b0000,2'd0},
    '{0,1,1,0,1,8'h60,8'h01,8'h00,4'b0000,2'd0},
    '{0,1,1,1,1,8'h60,8'h01,8'h00,4'b0000,2'd0},
    '{0,0,0,0,0,8'h00,8'h00,8'h00,4'b0000,2'd0},
    '{0,1,0,0,1,8'h61,8'h02,8'h00,4'b0000,2'd0},
    '{0,1,1,0,1,8'h61,8'h02,8'h00,4'b0000,2'd0},
    '{0,1,1,0,1,8'h61,8'h02,8'h00,4'b0000,2'd0},
    '{0,1,1,0,1,8'h61,8'h02,8'h00,4'b0000,2'd0},
    '{0,1,1,0,1,8'h61,8'h02,8'h00,4'b1000,2'd3},
    '{0,1,1,1,1,8'h61,8'h02,8'h00,4'b1000,2'd3}
  };

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 0; clr = 0; psel = 0; penable = 0; pwrite = 0; pready = 0;
    max_wait = 8'd4; paddr = 0; pwdata = 0; prdata = 0; pprot = 0; pstrb = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset flags", {28'd0, flags()}, 0);
    chk("R7 reset record", {first_valid, first_code, first_addr}, 0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].c, VEC[i].s, VEC[i].e, VEC[i].r, VEC[i].w, VEC[i].a, VEC[i].wd, VEC[i].rd);
      chk($sformatf("R1 R2 R3 R4 R9 flags vec %0d", i), {28'd0, flags()}, {28'd0, VEC[i].ef});
      chk($sformatf("R8 err_any vec %0d", i), err_any, |VEC[i].ef);
      if (VEC[i].ef != 0) chk($sformatf("R6 code vec %0d", i), first_code, VEC[i].ec);
    end

    // R5: clear and a new violation in the same cycle; timeout flag from table is set
    cyc(0,1,0,0,1,8'h70,8'h05,8'h00);
    cyc(0,1,1,0,1,8'h70,8'h05,8'h00);
    cyc(1,1,1,0,1,8'h72,8'h05,8'h00);
    chk("R5 clear with violation", {28'd0, flags()}, 4'b0001);
    chk("R6 relatch code", first_code, 2'd0);
    chk("R6 relatch addr", first_addr, 8'h72);
    cyc(0,1,1,1,1,8'h72,8'h05,8'h00);

    // R6: two rules in one cycle, lowest code wins; later ones do not overwrite
    cyc(1,0,0,0,0,8'h00,8'h00,8'h00);
    cyc(0,1,0,0,0,8'h80,8'h00,8'h00);
    cyc(0,1,1,0,0,8'h80,8'h00,8'h05);
    cyc(0,1,0,0,0,8'h81,8'h00,8'h05);
    chk("R6 priority flags", {28'd0, flags()}, 4'b0011);
    chk("R6 priority code", first_code, 2'd0);
    chk("R6 first addr", first_addr, 8'h81);
    cyc(0,0,0,0,0,8'h00,8'h00,8'h00);
    cyc(0,1,0,0,0,8'h90,8'h00,8'h00);
    cyc(0,1,1,0,0,8'h90,8'h00,8'h01);
    cyc(0,1,1,1,0,8'h90,8'h00,8'h02);
    chk("R6 later flags", {28'd0, flags()}, 4'b0111);
    chk("R6 no overwrite", {first_valid, first_code, first_addr}, {1'b1, 2'd0, 8'h81});

    // R1: pwdata ignored on a read wait, pstrb change caught
    cyc(1,0,0,0,0,8'h00,8'h00,8'h00);
    cyc(0,1,0,0,0,8'hA0,8'h01,8'h00);
    cyc(0,1,1,0,0,8'hA0,8'h01,8'h09);
    cyc(0,1,1,1,0,8'hA0,8'h02,8'h09);
    chk("R1 pwdata ignored on read", {28'd0, flags()}, 4'b0000);
    chk("R6 nothing recorded", first_valid, 1'b0);
    cyc(0,1,0,0,1,8'hA4,8'h01,8'h00);
    cyc(0,1,1,0,1,8'hA4,8'h01,8'h00);
    @(negedge clk) pstrb = 1'b0;
    cyc(0,1,1,1,1,8'hA4,8'h01,8'h00);
    chk("R1 pstrb change", {28'd0, flags()}, 4'b0001);
    pstrb = 1'b1;

    // R4: bound 0 disables the watchdog
    cyc(1,0,0,0,0,8'h00,8'h00,8'h00);
    max_wait = 8'd0;
    cyc(0,1,0,0,0,8'hB0,8'h00,8'h00);
    for (int k = 0; k < 10; k++) cyc(0,1,1,0,0,8'hB0,8'h00,8'h03);
    cyc(0,1,1,1,0,8'hB0,8'h00,8'h03);
    chk("R4 bound zero disables", {28'd0, flags()}, 4'b0000);

    // R4 / R9: back-to-back accesses with a fresh bound of 3
    max_wait = 8'd3;
    cyc(0,1,0,0,0,8'hC0,8'h00,8'h00);
    cyc(0,1,1,0,0,8'hC0,8'h00,8'h04);
    cyc(0,1,1,0,0,8'hC0,8'h00,8'h04);
    cyc(0,1,1,1,0,8'hC0,8'h00,8'h04);
    cyc(0,1,0,0,0,8'hC4,8'h00,8'h00);
    cyc(0,1,1,0,0,8'hC4,8'h00,8'h06);
    cyc(0,1,1,0,0,8'hC4,8'h00,8'h06);
    cyc(0,1,1,1,0,8'hC4,8'h00,8'h06);
    chk("R4 fresh bound each access", {28'd0, flags()}, 4'b0000);
    cyc(0,1,0,0,0,8'hC8,8'h00,8'h00);
    cyc(0,1,1,0,0,8'hC8,8'h00,8'h07);
    cyc(0,1,1,0,0,8'hC8,8'h00,8'h07);
    chk("R9 no timeout before bound", err_timeout, 1'b0);
    cyc(0,1,1,0,0,8'hC8,8'h00,8'h07);
    chk("R9 timeout at bound", {28'd0, flags()}, 4'b1000);
    chk("R6 timeout record", {first_code, first_addr}, {2'd3, 8'hC8});
    cyc(0,1,1,1,0,8'hC8,8'h00,8'h07);

    // R7: reset in the middle clears everything
    @(negedge clk) rst_n = 0;
    @(posedge clk);
    #1;
    chk("R7 mid-run reset flags", {28'd0, flags()}, 0);
    chk("R7 mid-run reset record", {first_valid, first_code, first_addr}, 0);
    @(negedge clk) rst_n = 1;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule